// File: doc/BRIEF.md
# Dual-Tone Spur Canceller

This block sits in the sample path between a digital synthesizer core and its DAC. It removes two known spurious tones from the stream by subtracting two locally generated replica tones. Each replica comes from a small phase-accumulator oscillator. The host sets each oscillator's tuning word, phase offset and signed amplitude to match one spur. The datapath subtracts both replicas from the incoming sample. It then clamps the result to the sample width and registers it for the DAC.

Each replica has a waveform close to a sine. The waveform is computed arithmetically with a parabolic approximation, so no table is stored. The block does not search for spur frequencies; the host supplies every parameter. All configuration inputs may change while the block runs. A change takes effect at the next clock edge.

Top module: `spur_cancel_top`

## Requirements
- R1: While `rstN` is low, `outSample` is 0 and both phase accumulators are 0.
- R2: Exactly two channels exist. On each rising edge where `chanEn[i]` is 1, accumulator i advances by `tuneWord[i]` modulo 2^PHW.
- R3: Channel i's waveform index is the top LW bits of (accumulator + `phaseOff[i]`) modulo 2^PHW. The index MSB is the sign bit. The low LW-1 bits form u, and h = 2^(LW-1). The magnitude is floor(4·u·(h−u)/h), and the waveform value is ±magnitude. With the defaults, h is 512.
- R4: Replicas are applied in opposite phase: `outSample` = clamp(`inSample` − tone0 − tone1).
- R5: tone = floor(wave·amp / 2^(LW−1)), with `ampVal` taken as two's complement. A phase offset of a quarter turn (0x400000 with the defaults) and an accumulator at 0 give tone = amp. A three-quarter turn gives tone = −amp, and an eighth turn gives tone = floor(384·amp/512).
- R6: A channel whose `chanEn` bit is 0 contributes exactly 0. Its accumulator is cleared to 0 on that edge, so it restarts from its offset when re-enabled.
- R7: A channel whose `ampVal` is 0 contributes exactly 0.
- R8: The sum saturates to the SW-bit signed range (−32768..32767 with the defaults) and never wraps.
- R9: `outSample` reflects the inputs present at the preceding rising edge. It is one register stage, and it holds between edges.
- R10: A changed tuning word applies from the next edge without resetting the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock shared by the stream and both oscillators |
| rstN | input | 1 | Active-low synchronous reset |
| inSample | input | SW | Signed sample from the synthesizer core |
| chanEn | input | 2 | Per-channel enable |
| tuneWord | input | 2×PHW | Per-channel phase increment |
| phaseOff | input | 2×PHW | Per-channel phase offset |
| ampVal | input | 2×AW | Per-channel signed amplitude |
| outSample | output | SW | Corrected, saturated, registered sample |

## Verification
The hardest case to set up is a moving accumulator under a tuning word that changes mid-run. It is hard because the accumulator phase is visible only through the replica it produces. The bench first disables both channels for one edge to force a known zero phase. It then enables them with unrelated tuning words and steps an independent phase model in lock with the clock. Partway through, it changes one tuning word and compares every output against the model. Static cases use a zero tuning word, so the phase offset alone selects a known point on the waveform.

// File: rtl/spur_pkg.sv
package spur_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic [NCH-1:0] adv;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] mute;
  } spurStrobe_t;
endpackage

// File: rtl/spur_tone.sv
module spur_tone #(
  parameter int PHW = 24,
  parameter int LW  = 10,
  parameter int AW  = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 adv,
  input  logic                 clr,
  input  logic                 mute,
  input  logic [PHW-1:0]       tune,
  input  logic [PHW-1:0]       off,
  input  logic [AW-1:0]        amp,
  output logic [PHW-1:0]       acc,
  output logic signed [AW:0]   tone
);
  localparam int HALF = 1 << (LW - 1);
  localparam int MW   = 2 * LW - 2;

  logic [PHW-1:0]        ph;
  logic [LW-1:0]         idx;
  logic [LW-2:0]         u;
  logic [MW-1:0]         magFull;
  logic [LW-1:0]         mag;
  logic signed [LW:0]    magS;
  logic signed [LW:0]    wave;
  logic signed [LW+AW:0] prod;
  logic signed [AW:0]    toneRaw;

  always_ff @(posedge clk) begin
    if (!rstN)    acc <= '0;
    else if (clr) acc <= '0;
    else if (adv) acc <= acc + tune;
  end

  always_comb begin
    ph      = acc + off;
    idx     = LW'(ph >> (PHW - LW));
    u       = idx[LW-2:0];
    magFull = MW'(u) * (MW'(HALF) - MW'(u));
    mag     = LW'(magFull >> (LW - 3));
    magS    = $signed({1'b0, mag});
    wave    = idx[LW-1] ? -magS : magS;
    prod    = wave * $signed(amp);
    toneRaw = (AW+1)'(prod >>> (LW - 1));
    tone    = mute ? '0 : toneRaw;
  end
endmodule

// File: rtl/spur_ctrl.sv
module spur_ctrl
  import spur_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [NCH-1:0]         chanEn,
  input  logic [NCH-1:0][AW-1:0] ampVal,
  output spurStrobe_t            strb
);
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      strb.adv[i]  = chanEn[i];
      strb.clr[i]  = ~chanEn[i];
      strb.mute[i] = ~chanEn[i] | (ampVal[i] == '0);
    end
  end
endmodule

// File: rtl/spur_dpath.sv
module spur_dpath
  import spur_pkg::*;
#(
  parameter int SW  = 16,
  parameter int PHW = 24,
  parameter int LW  = 10,
  parameter int AW  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  spurStrobe_t             strb,
  input  logic signed [SW-1:0]    inSample,
  input  logic [NCH-1:0][PHW-1:0] tuneWord,
  input  logic [NCH-1:0][PHW-1:0] phaseOff,
  input  logic [NCH-1:0][AW-1:0]  ampVal,
  output logic [NCH-1:0][PHW-1:0] phaseAcc,
  output logic [NCH-1:0][AW:0]    toneV,
  output logic signed [SW-1:0]    outSample
);
  localparam int TW = SW + 2;
  localparam logic signed [TW-1:0] HI = TW'((1 << (SW - 1)) - 1);
  localparam logic signed [TW-1:0] LO = -HI - TW'(1);

  logic signed [TW-1:0] total;
  logic signed [SW-1:0] clamped;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic signed [AW:0] t;
    spur_tone #(.PHW(PHW), .LW(LW), .AW(AW)) u_tone (
      .clk  (clk),
      .rstN (rstN),
      .adv  (strb.adv[g]),
      .clr  (strb.clr[g]),
      .mute (strb.mute[g]),
      .tune (tuneWord[g]),
      .off  (phaseOff[g]),
      .amp  (ampVal[g]),
      .acc  (phaseAcc[g]),
      .tone (t)
    );
    assign toneV[g] = t;
  end

  always_comb begin
    total = {{2{inSample[SW-1]}}, inSample};
    for (int i = 0; i < NCH; i++)
      total = total - {{(TW-AW-1){toneV[i][AW]}}, toneV[i]};
    if (total > HI)      clamped = SW'(HI);
    else if (total < LO) clamped = SW'(LO);
    else                 clamped = SW'(total);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outSample <= '0;
    else       outSample <= clamped;
  end
endmodule

// File: rtl/spur_cancel_top.sv
module spur_cancel_top
  import spur_pkg::*;
#(
  parameter int SW  = 16,
  parameter int PHW = 24,
  parameter int LW  = 10,
  parameter int AW  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [SW-1:0]    inSample,
  input  logic [NCH-1:0]          chanEn,
  input  logic [NCH-1:0][PHW-1:0] tuneWord,
  input  logic [NCH-1:0][PHW-1:0] phaseOff,
  input  logic [NCH-1:0][AW-1:0]  ampVal,
  output logic signed [SW-1:0]    outSample
);
  spurStrobe_t             strb;
  logic [NCH-1:0][PHW-1:0] phaseAcc;
  logic [NCH-1:0][AW:0]    toneV;

  spur_ctrl #(.AW(AW)) u_ctrl (
    .chanEn (chanEn),
    .ampVal (ampVal),
    .strb   (strb)
  );

  spur_dpath #(.SW(SW), .PHW(PHW), .LW(LW), .AW(AW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inSample  (inSample),
    .tuneWord  (tuneWord),
    .phaseOff  (phaseOff),
    .ampVal    (ampVal),
    .phaseAcc  (phaseAcc),
    .toneV     (toneV),
    .outSample (outSample)
  );
endmodule

// File: rtl/spur_cancel_chk.sv
module spur_cancel_chk
  import spur_pkg::*;
#(
  parameter int SW  = 16,
  parameter int PHW = 24,
  parameter int LW  = 10,
  parameter int AW  = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [SW-1:0]    inSample,
  input logic [NCH-1:0]          chanEn,
  input logic [NCH-1:0][PHW-1:0] tuneWord,
  input logic [NCH-1:0][AW-1:0]  ampVal,
  input logic signed [SW-1:0]    outSample,
  input logic [NCH-1:0][PHW-1:0] phaseAcc,
  input logic [NCH-1:0][AW:0]    toneV
);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (SW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic allQuiet;
  logic allNonPos;
  logic allNonNeg;
  always_comb begin
    allQuiet  = 1'b1;
    allNonPos = 1'b1;
    allNonNeg = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      allQuiet  = allQuiet & (~chanEn[i] | (ampVal[i] == '0));
      allNonPos = allNonPos & (toneV[i][AW] | (toneV[i] == '0));
      allNonNeg = allNonNeg & ~toneV[i][AW];
    end
  end

  // R6 R7 R9
  quiet_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    allQuiet |=> outSample == $past(inSample));

  // R8
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSample == MAXV && allNonPos) |=> outSample == MAXV);

  // R8
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSample == MINV && allNonNeg) |=> outSample == MINV);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanEn[g] |=> phaseAcc[g] == PHW'($past(phaseAcc[g]) + $past(tuneWord[g])));

    // R6
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !chanEn[g] |=> phaseAcc[g] == '0);

    // R6 R7
    tone_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!chanEn[g] || ampVal[g] == '0) |-> toneV[g] == '0);
  end
endmodule

bind spur_cancel_top spur_cancel_chk #(.SW(SW), .PHW(PHW), .LW(LW), .AW(AW)) u_chk (.*);

// File: tb/sim_spur_cancel_top.sv
module sim_spur_cancel_top;
  logic                    clk = 1'b0;
  logic                    rstN;
  logic signed [15:0]      inSample;
  logic [1:0]              chanEn;
  logic [1:0][23:0]        tuneWord;
  logic [1:0][23:0]        phaseOff;
  logic [1:0][11:0]        ampVal;
  logic signed [15:0]      outSample;

  int nRun  = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  spur_cancel_top u0 (
    .clk(clk), .rstN(rstN), .inSample(inSample), .chanEn(chanEn),
    .tuneWord(tuneWord), .phaseOff(phaseOff), .ampVal(ampVal),
    .outSample(outSample)
  );

  typedef struct packed {
    logic [1:0]  en;
    logic [23:0] p0;
    logic [11:0] a0;
    logic [23:0] p1;
    logic [11:0] a1;
    logic [15:0] din;
    logic [15:0] dexp;
  } vec_t;

  localparam logic [23:0] QT = 24'h400000;
  localparam logic [23:0] TQ = 24'hC00000;
  localparam logic [23:0] ET = 24'h200000;

  localparam vec_t VECS [9] = '{
    '{2'b00, QT, 12'sd1000,  QT, 12'sd500,   16'sd1234,   16'sd1234},   // R6
    '{2'b01, QT, 12'sd1000,  QT, 12'sd500,   16'sd1234,   16'sd234},    // R4 R5
    '{2'b11, QT, 12'sd1000,  TQ, 12'sd500,   16'sd0,     -16'sd500},    // R4 R5
    '{2'b11, QT, 12'sd0,     TQ, 12'sd0,    -16'sd777,  -16'sd777},     // R7
    '{2'b11, ET, 12'sd1000,  ET, -12'sd1000, 16'sd100,    16'sd100},    // R3 R5
    '{2'b10, QT, 12'sd5,     QT, 12'sd2047, -16'sd32000, -16'sd32768},  // R8
    '{2'b11, TQ, 12'sd2047,  TQ, 12'sd2047,  16'sd32000,  16'sd32767},  // R8
    '{2'b01, 24'h0, 12'sd2047, QT, 12'sd9,   16'sd55,     16'sd55},     // R3
    '{2'b11, QT, -12'sd2048, QT, -12'sd2048, 16'sd30000,  16'sd32767}   // R8
  };

  function automatic longint toneOf(longint acc, longint off, longint amp);
    longint ph  = (acc + off) & 64'hFFFFFF;
    longint idx = ph >> 14;
    longint u   = idx & 511;
    longint mag = (4 * u * (512 - u)) / 512;
    longint w   = ((idx >> 9) & 1) != 0 ? -mag : mag;
    return (w * amp) >>> 9;
  endfunction

  function automatic logic [15:0] clampOf(longint v);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    longint m0, m1, e;
    rstN = 1'b0; inSample = 16'sd4321; chanEn = 2'b11;
    tuneWord = '0; phaseOff = '0; ampVal = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset output", outSample, 16'h0);
    @(negedge clk) rstN = 1'b1;

    // static table: zero tuning words, offset alone sets the waveform point
    foreach (VECS[k]) begin
      @(negedge clk);
      chanEn = VECS[k].en;
      phaseOff[0] = VECS[k].p0; ampVal[0] = VECS[k].a0;
      phaseOff[1] = VECS[k].p1; ampVal[1] = VECS[k].a1;
      inSample = VECS[k].din;
      @(posedge clk); #1;
      check($sformatf("R3-R8 vector %0d", k), outSample, VECS[k].dexp);
    end

    // R9 latency: one register stage, holds between edges
    @(negedge clk); chanEn = 2'b00; inSample = 16'sd222;
    @(posedge clk);
    @(negedge clk); inSample = 16'sd1111;
    #1 check("R9 holds before edge", outSample, 16'sd222);
    @(posedge clk); #1 check("R9 updates at edge", outSample, 16'sd1111);

    // R2 R10 running oscillators against a phase model
    @(negedge clk);
    chanEn = 2'b11;
    tuneWord[0] = 24'h012345; tuneWord[1] = 24'h0A0001;
    phaseOff[0] = ET; phaseOff[1] = 24'h0;
    ampVal[0] = 12'sd1500; ampVal[1] = -12'sd700;
    m0 = 0; m1 = 0;
    for (int c = 0; c < 20; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 10) tuneWord[0] = 24'h3F0F0F;
      inSample = 16'(c * 37 - 300);
      e = longint'(inSample) - toneOf(m0, longint'(phaseOff[0]), longint'($signed(ampVal[0])))
                             - toneOf(m1, longint'(phaseOff[1]), longint'($signed(ampVal[1])));
      @(posedge clk); #1;
      check(c >= 10 ? "R10 retune running" : "R2 accumulate", outSample, clampOf(e));
      m0 = (m0 + longint'(tuneWord[0])) & 64'hFFFFFF;
      m1 = (m1 + longint'(tuneWord[1])) & 64'hFFFFFF;
    end

    // R6 disable clears accumulator; re-enable restarts from offset
    @(negedge clk); chanEn = 2'b00;
    @(posedge clk);
    @(negedge clk);
    chanEn = 2'b01; tuneWord[0] = 24'h0; phaseOff[0] = QT;
    ampVal[0] = 12'sd300; inSample = 16'sd0;
    @(posedge clk); #1 check("R6 restart from offset", outSample, -16'sd300);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0; inSample = 16'sd999;
    @(posedge clk); #1 check("R1 reset mid-run", outSample, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule